// File: doc/BRIEF.md
# Three-wire tuning control register

This block takes a tuning control word from a host over three slow lines (serial data, serial clock and a word-enable) and turns it into the static control fields that steer a frequency synthesiser. The lines are sampled in the system clock domain through a short synchroniser chain, and edges are found on the sampled clock and enable. Data bits are taken on rising serial clock edges seen while the enable is high, most significant bit first. A rising serial clock edge seen while the enable is low is dropped.

When the enable falls, the word is accepted only if exactly the expected number of bits came in. An accepted word is placed in a pending register. The driven outputs take the pending word on the next system clock in which the divider signals its terminal count, so a new ratio always starts on a whole divider cycle. A parameter selects either the wide layout with four switching ports (28 bits) or the narrow layout with two (26 bits). Both layouts share the low 24 bits.

Top module: `serial_tune_ctrl`

## Requirements
- R1: After a synchronous reset every output field is 0 and no word is pending.
- R2: A rising serial clock edge while enable is low shifts nothing. The bit count is cleared while enable is low, so stray clocks before a frame do not change the word accepted afterwards.
- R3: Bits enter most significant first. Word bit positions, with W = 24 + PORT_BITS: [16:0] divider ratio, [17] prescaler on, [20:18] reference ratio select, [21] charge pump high current, [22] test mode, [23] varactor drive off, [W-1:24] switching ports.
- R4: An enable fall after exactly W data bits places the word in the pending register. The outputs do not change at that point.
- R5: An enable fall after fewer or more than W bits discards the word. The outputs and any earlier pending word are kept.
- R6: The outputs change only on a clock in which div_tc is high. They then take the pending word, and the pending flag clears.
- R7: If two words are accepted before a div_tc, the later word is the one that gets applied.
- R8: If an accepted word and div_tc fall on the same clock, the word that was already pending is applied (none if the register was empty). The new word stays pending for the next div_tc.
- R9: div_tc with nothing pending leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_data | input | 1 | Serial data line, asynchronous |
| ser_clk | input | 1 | Serial clock line, asynchronous |
| ser_en | input | 1 | Word enable line, asynchronous |
| div_tc | input | 1 | One-cycle strobe at the divider terminal count |
| div_ratio | output | 17 | Applied divider ratio |
| presc_on | output | 1 | Divide-by-two prescaler in use |
| ref_sel | output | 3 | Reference ratio select |
| cp_high | output | 1 | Charge pump high current |
| test_mode | output | 1 | Test mode select |
| vdrive_off | output | 1 | Varactor drive switched off |
| port_out | output | PORT_BITS | Switching port outputs |

## Verification
An enable fall or a serial clock rise that is set up before system clock edge e is acted on at edge e+2. That delay comes from the two synchroniser flops and the flop that holds the previous sample. So a word becomes pending at e+2, and the outputs move on the first later edge at which div_tc is sampled high. The bench drives all lines on falling edges. A behavioural model keeps the last three sampled line values and the pending word, and the outputs are compared with that model on every falling edge, half a cycle after each update. Directed checks also compare exact expected words after each scenario. The same-clock case (R8) is driven by raising div_tc exactly two falling edges after the enable drop.

// File: rtl/tune_pkg.sv
package tune_pkg;
    localparam int RATIO_W = 17;
    localparam int REF_W   = 3;
    localparam int CORE_W  = RATIO_W + REF_W + 4;

    typedef struct packed {
        logic               vdrive_off;
        logic               test_mode;
        logic               cp_high;
        logic [REF_W-1:0]   ref_sel;
        logic               presc_on;
        logic [RATIO_W-1:0] ratio;
    } tune_core_t;

    function automatic int word_bits(input int ports);
        return CORE_W + ports;
    endfunction
endpackage

// File: rtl/tune_sync.sv
module tune_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [STAGES-1:0][N-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[STAGES-2:0], d};
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/tune_shifter.sv
module tune_shifter #(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         s_clk,
    input  logic         s_en,
    input  logic         s_dat,
    output logic         load,
    output logic [W-1:0] word
);
    localparam int CNT_W   = $clog2(W + 2);
    localparam int CNT_MAX = W + 1;

    logic             clk_q, en_q;
    logic [W-1:0]     sr;
    logic [CNT_W-1:0] cnt;
    logic             rise, fall;

    assign rise = s_clk & ~clk_q & s_en;
    assign fall = ~s_en & en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q <= 1'b0;
            en_q  <= 1'b0;
            sr    <= '0;
            cnt   <= '0;
        end else begin
            clk_q <= s_clk;
            en_q  <= s_en;
            if (!s_en) begin
                cnt <= '0;
            end else if (rise) begin
                sr <= {sr[W-2:0], s_dat};
                if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
            end
        end
    end

    assign load = fall && (cnt == CNT_W'(W));
    assign word = sr;
endmodule

// File: rtl/tune_hold.sv
module tune_hold #(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] word,
    input  logic         div_tc,
    output logic         pend_v,
    output logic [W-1:0] applied
);
    logic [W-1:0] pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= '0;
            pend_v  <= 1'b0;
            applied <= '0;
        end else begin
            if (div_tc && pend_v) applied <= pend;
            if (load) begin
                pend   <= word;
                pend_v <= 1'b1;
            end else if (div_tc) begin
                pend_v <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/serial_tune_ctrl.sv
module serial_tune_ctrl
    import tune_pkg::*;
#(
    parameter int PORT_BITS   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ser_data,
    input  logic                 ser_clk,
    input  logic                 ser_en,
    input  logic                 div_tc,
    output logic [RATIO_W-1:0]   div_ratio,
    output logic                 presc_on,
    output logic [REF_W-1:0]     ref_sel,
    output logic                 cp_high,
    output logic                 test_mode,
    output logic                 vdrive_off,
    output logic [PORT_BITS-1:0] port_out
);
    localparam int WORD_W = word_bits(PORT_BITS);

    logic [2:0]        synced;
    logic              load_w;
    logic              pend_v_w;
    logic [WORD_W-1:0] shift_word;
    logic [WORD_W-1:0] out_word;
    tune_core_t        core;

    tune_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ser_en, ser_clk, ser_data}),
        .q   (synced)
    );

    tune_shifter #(.W(WORD_W)) u_shift (
        .clk   (clk),
        .rst   (rst),
        .s_clk (synced[1]),
        .s_en  (synced[2]),
        .s_dat (synced[0]),
        .load  (load_w),
        .word  (shift_word)
    );

    tune_hold #(.W(WORD_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .load    (load_w),
        .word    (shift_word),
        .div_tc  (div_tc),
        .pend_v  (pend_v_w),
        .applied (out_word)
    );

    assign core       = tune_core_t'(out_word[CORE_W-1:0]);
    assign div_ratio  = core.ratio;
    assign presc_on   = core.presc_on;
    assign ref_sel    = core.ref_sel;
    assign cp_high    = core.cp_high;
    assign test_mode  = core.test_mode;
    assign vdrive_off = core.vdrive_off;
    assign port_out   = out_word[WORD_W-1:CORE_W];
endmodule

// File: rtl/tune_ctrl_chk.sv
module tune_ctrl_chk #(
    parameter int W = 28
) (
    input logic         clk,
    input logic         rst,
    input logic         div_tc,
    input logic         load,
    input logic         pend_v,
    input logic [W-1:0] out_word
);
    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (out_word == '0) && !pend_v);

    // R4
    a_r4_accept_pends: assert property (@(posedge clk) disable iff (rst)
        load |=> pend_v);

    // R6
    a_r6_hold_without_tc: assert property (@(posedge clk) disable iff (rst)
        !div_tc |=> $stable(out_word));

    // R6
    a_r6_tc_drains: assert property (@(posedge clk) disable iff (rst)
        (div_tc && pend_v && !load) |=> !pend_v);

    // R9
    a_r9_idle_tc: assert property (@(posedge clk) disable iff (rst)
        (div_tc && !pend_v) |=> $stable(out_word));
endmodule

bind serial_tune_ctrl tune_ctrl_chk #(.W(WORD_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .div_tc   (div_tc),
    .load     (load_w),
    .pend_v   (pend_v_w),
    .out_word (out_word)
);

// File: tb/test_serial_tune_ctrl.sv
`timescale 1ns/1ps
module test_serial_tune_ctrl;
    localparam int PB = 4;
    localparam int W  = 24 + PB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sd = 1'b0, sc = 1'b0, se = 1'b0, tc = 1'b0;

    logic [16:0]   div_ratio;
    logic          presc_on;
    logic [2:0]    ref_sel;
    logic          cp_high, test_mode, vdrive_off;
    logic [PB-1:0] port_out;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    serial_tune_ctrl #(.PORT_BITS(PB)) i_serial_tune_ctrl (
        .clk(clk), .rst(rst), .ser_data(sd), .ser_clk(sc), .ser_en(se),
        .div_tc(tc), .div_ratio(div_ratio), .presc_on(presc_on),
        .ref_sel(ref_sel), .cp_high(cp_high), .test_mode(test_mode),
        .vdrive_off(vdrive_off), .port_out(port_out)
    );

    function automatic logic [W-1:0] seen();
        return {port_out, vdrive_off, test_mode, cp_high, ref_sel, presc_on, div_ratio};
    endfunction

    // behavioural reference: line samples delayed by three edges
    logic [2:0]   p1, p2, p3;   // {en, clk, data}
    logic [W-1:0] m_sr, m_pend, m_act;
    bit           m_pv;
    int           m_cnt;

    always @(posedge clk) begin
        if (rst) begin
            p1 = '0; p2 = '0; p3 = '0;
            m_sr = '0; m_pend = '0; m_act = '0; m_pv = 0; m_cnt = 0;
        end else begin
            if (tc && m_pv) m_act = m_pend;
            if (!p2[2] && p3[2] && m_cnt == W) begin
                m_pend = m_sr; m_pv = 1;
            end else if (tc) begin
                m_pv = 0;
            end
            if (!p2[2]) m_cnt = 0;
            else if (p2[1] && !p3[1]) begin
                m_sr = {m_sr[W-2:0], p2[0]};
                m_cnt = m_cnt + 1;
            end
            p3 = p2; p2 = p1; p1 = {se, sc, sd};
        end
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) chk(seen() === m_act, "R6 outputs vs model", seen(), m_act);
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [63:0] v, input int n);
        @(negedge clk); se = 1'b1; idle(3);
        for (int i = n - 1; i >= 0; i--) begin
            sd = v[i]; idle(2);
            sc = 1'b1; idle(3);
            sc = 1'b0; idle(2);
        end
        idle(2); se = 1'b0; idle(6);
    endtask

    task automatic strobe();
        @(negedge clk); tc = 1'b1;
        @(negedge clk); tc = 1'b0;
        idle(2);
    endtask

    localparam logic [W-1:0] WA = 28'hA53C17E;
    localparam logic [W-1:0] WC = 28'h5F00A3B;
    localparam logic [W-1:0] WD = 28'h3E1D2C4;
    localparam logic [W-1:0] WE = 28'hC0FFEE1;
    localparam logic [W-1:0] WF = 28'h7B4A961;

    initial begin
        #(200000 * 8);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(4);
        rst = 1'b0;
        idle(2);
        chk(seen() === '0, "R1 reset outputs", seen(), '0);

        send(64'(WA), W);
        idle(5);
        chk(seen() === '0, "R4 pending not applied", seen(), '0);
        strobe();
        chk(seen() === WA, "R6 applied on tc", seen(), WA);
        chk(div_ratio === WA[16:0], "R3 ratio field", W'(div_ratio), W'(WA[16:0]));
        chk(port_out === WA[27:24], "R3 port field", W'(port_out), W'(WA[27:24]));
        chk({vdrive_off, test_mode, cp_high, ref_sel, presc_on} === WA[23:17],
            "R3 control fields", W'({vdrive_off, test_mode, cp_high, ref_sel, presc_on}),
            W'(WA[23:17]));

        send(64'h1234567, W - 1);
        strobe();
        chk(seen() === WA, "R5 short word discarded", seen(), WA);
        send(64'h0ABCDEF1, W + 1);
        strobe();
        chk(seen() === WA, "R5 long word discarded", seen(), WA);

        // stray serial clocks while enable low
        for (int k = 0; k < 5; k++) begin
            sd = 1'b1; idle(2); sc = 1'b1; idle(3); sc = 1'b0; idle(2);
        end
        idle(4);
        chk(seen() === WA, "R2 stray clocks no effect", seen(), WA);
        send(64'(WC), W);
        strobe();
        chk(seen() === WC, "R2 word after stray clocks", seen(), WC);

        send(64'(WD), W);
        send(64'(WE), W);
        strobe();
        chk(seen() === WE, "R7 later word wins", seen(), WE);

        strobe();
        chk(seen() === WE, "R9 tc with nothing pending", seen(), WE);

        // R8: WD pending, WF accepted on the same edge as tc
        send(64'(WD), W);
        @(negedge clk); se = 1'b1; idle(3);
        for (int i = W - 1; i >= 0; i--) begin
            sd = WF[i]; idle(2); sc = 1'b1; idle(3); sc = 1'b0; idle(2);
        end
        idle(2);
        se = 1'b0;
        idle(2);
        tc = 1'b1;
        @(negedge clk); tc = 1'b0;
        idle(1);
        chk(seen() === WD, "R8 old pending applied on shared edge", seen(), WD);
        strobe();
        chk(seen() === WF, "R8 new word kept for next tc", seen(), WF);

        idle(4);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule